// File: doc/BRIEF.md
# Double-Buffered Per-Channel Colour Curve Table

This block applies an independent one-dimensional transfer curve to the red, green and blue components of a pixel stream. Each channel owns two banks of table memory. Software fills one bank through a small register port while the other bank shapes live pixels. At a frame boundary it then flips the active bank, so a new curve never appears half-way down a picture. Between two neighbouring table entries the output is found by straight-line interpolation, so a coarse table still yields a smooth curve.

The host addresses three registers. The control register holds the requested operating mode and the requested pixel bank. It also holds the bank that data writes go to, a three-bit channel write mask and a memory power-force bit. The index register sets the table write pointer. Each write to the data register stores one entry and advances that pointer. One data stream can therefore fill all three channels together, or one channel at a time. While the memory is forced into low power, or is still waking up, the block ignores table writes and passes pixels through unchanged.

Top module: `lut1d_dbuf`

## Requirements
- R1: After reset, the control register reads 0x00000070. That is mode request 0, select request 0, host bank 0, write mask 7, power-force 0, current mode 0, current select 0 and power state 0. The index register reads 0.
- R2: Current mode value 2 selects table output. Current mode values 0, 1 and 3 all give an output equal to the input.
- R3: Current select 0 makes pixels use bank A and 1 makes them use bank B. Control bit 3, the host bank, routes data writes to bank A (0) or bank B (1) on its own, whatever the current select is.
- R4: The mode request (control [1:0]) and select request (control bit 2) reach the current mode (control [17:16]) and current select (control bit 18) only on a cycle with `frame_start` high. If a control write falls in that same cycle, the value latched is the request held before the write.
- R5: In control [6:4] the write mask stores into red when bit 6 is set, green when bit 5 is set and blue when bit 4 is set. Mask 7 writes the same value to all three channels.
- R6: A write to the index register (address 1) sets the write pointer. Each accepted write to the data register (address 2) stores at the pointer and then adds one to it. Writes at a pointer beyond the last entry are dropped.
- R7: A table holds 2^IDX_W entries plus one upper endpoint entry. The upper IDX_W bits of a component form the entry number i, and the lower bits form the fraction f. The output is e[i] + floor((e[i+1] - e[i]) * f / 2^(DATA_W-IDX_W)). The output appears 3 cycles after the input, with `pix_valid_o` matching `pix_valid_i`.
- R8: While power-force (control bit 8) is 1, the power state (control bit 19) reads 1. After power-force is cleared, the power state stays at 1 for PWR_LAT cycles and then reads 0.
- R9: While the power state is 1, data-register writes change neither the table nor the write pointer, and pixels pass through unchanged.
- R10: Data writes to the bank that is not active for pixels leave the output stream unchanged, even when they fall in the same cycle as a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 index, 2 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` of the previous cycle |
| frame_start | input | 1 | Frame boundary strobe that applies the mode and select requests |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_r_i | input | DATA_W | Red component in |
| pix_g_i | input | DATA_W | Green component in |
| pix_b_i | input | DATA_W | Blue component in |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_r_o | output | DATA_W | Red component out |
| pix_g_o | output | DATA_W | Green component out |
| pix_b_o | output | DATA_W | Blue component out |

## Verification
Two kinds of event can land in the same clock edge. The first is a host data write and a pixel lookup. The bench forks a table write to the idle bank alongside a pixel sent through the active bank. It then requires that the pixel matches the unchanged active curve, and that selecting the other bank later shows the new entry. The second is a control write and a frame strobe. Both are driven in one cycle, and the bench requires that the current-select status and the pixel path still show the old request until a further strobe.

// File: rtl/lut1d_pkg.sv
package lut1d_pkg;
  localparam int REG_W = 32;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_IDX  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam logic [1:0] MODE_TABLE = 2'd2;

  // control register field positions
  localparam int F_MODE   = 0;   // [1:0]
  localparam int F_SEL    = 2;
  localparam int F_HOST   = 3;
  localparam int F_MASK   = 4;   // [6:4]
  localparam int F_FORCE  = 8;
endpackage

// File: rtl/lut1d_ctrl.sv
module lut1d_ctrl
  import lut1d_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int IDX_W   = 4,
  parameter int PWR_LAT = 8,
  localparam int AW     = $clog2((2**IDX_W) + 1),
  localparam int CW     = $clog2(PWR_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              frame_start,
  output logic              lut_on,
  output logic              sel_cur,
  output logic              host_sel,
  output logic [2:0]        wmask,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic [1:0]    mode_req, mode_cur;
  logic          sel_req;
  logic          force_q;
  logic [AW-1:0] index_q;
  logic [CW-1:0] pwr_cnt;
  logic          pwr_busy;
  logic          ctrl_wr, idx_wr, data_wr;
  logic          unused_wdata;

  assign unused_wdata = ^reg_wdata[REG_W-1:DATA_W];

  assign ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
  assign idx_wr   = reg_wr && (reg_addr == ADDR_IDX);
  assign data_wr  = reg_wr && (reg_addr == ADDR_DATA);
  assign pwr_busy = force_q || (pwr_cnt != '0);
  assign wr_en    = data_wr && !pwr_busy;
  assign wr_addr  = index_q;
  assign wr_data  = reg_wdata[DATA_W-1:0];
  assign lut_on   = (mode_cur == MODE_TABLE) && !pwr_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_req <= '0;
      sel_req  <= 1'b0;
      host_sel <= 1'b0;
      wmask    <= 3'b111;
      force_q  <= 1'b0;
      mode_cur <= '0;
      sel_cur  <= 1'b0;
      index_q  <= '0;
      pwr_cnt  <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_req <= reg_wdata[F_MODE +: 2];
        sel_req  <= reg_wdata[F_SEL];
        host_sel <= reg_wdata[F_HOST];
        wmask    <= reg_wdata[F_MASK +: 3];
        force_q  <= reg_wdata[F_FORCE];
      end
      if (frame_start) begin
        mode_cur <= mode_req;
        sel_cur  <= sel_req;
      end
      if (idx_wr)     index_q <= reg_wdata[AW-1:0];
      else if (wr_en) index_q <= index_q + AW'(1);
      if (ctrl_wr && force_q && !reg_wdata[F_FORCE]) pwr_cnt <= CW'(PWR_LAT);
      else if (!force_q && pwr_cnt != '0)            pwr_cnt <= pwr_cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (reg_addr)
        ADDR_CTRL: reg_rdata <= {12'd0, pwr_busy, sel_cur, mode_cur, 7'd0, force_q,
                                 1'b0, wmask, host_sel, sel_req, mode_req};
        ADDR_IDX:  reg_rdata <= {{(REG_W-AW){1'b0}}, index_q};
        default:   reg_rdata <= '0;
      endcase
    end
  end

  // R4: current mode and select only move on a frame strobe
  assert_cur_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(mode_cur) && $stable(sel_cur)));

  // R6: every accepted data write advances the pointer by one
  assert_idx_step_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !idx_wr) |=> (index_q == $past(index_q) + AW'(1)));

  // R8: clearing power-force leaves the memory busy while it wakes
  assert_wake_busy_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(force_q) && !force_q) |-> pwr_busy);

  // R9: data writes during low power leave the pointer alone
  assert_lowpwr_idx_R9: assert property (@(posedge clk) disable iff (rst)
    (pwr_busy && data_wr && !idx_wr) |=> $stable(index_q));
endmodule

// File: rtl/lut1d_chan.sv
module lut1d_chan #(
  parameter int DATA_W  = 12,
  parameter int IDX_W   = 4,
  localparam int FRAC_W  = DATA_W - IDX_W,
  localparam int ENTRIES = (2**IDX_W) + 1,
  localparam int AW      = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lut_on,
  input  logic              sel,
  input  logic              pix_valid_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic              pix_valid_o,
  output logic [DATA_W-1:0] pix_o
);
  logic [DATA_W-1:0] mem [2][ENTRIES];
  logic [DATA_W-1:0] rd_lo [2];
  logic [DATA_W-1:0] rd_hi [2];
  logic [AW-1:0]     lo_a, hi_a;

  logic              s1_vld, s1_use, s1_sel;
  logic [FRAC_W-1:0] s1_frac;
  logic [DATA_W-1:0] s1_pix;
  logic              s2_vld, s2_use;
  logic [DATA_W-1:0] s2_pix, s2_val;

  logic [DATA_W-1:0]               lo, hi;
  logic signed [DATA_W:0]          diff;
  logic signed [DATA_W+FRAC_W+1:0] prod, sum;

  assign lo_a = AW'(pix_i[DATA_W-1 -: IDX_W]);
  assign hi_a = lo_a + AW'(1);

  // table banks: one write port, two synchronous read ports per bank
  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < AW'(ENTRIES))) mem[wr_bank][wr_addr] <= wr_data;
    for (int b = 0; b < 2; b++) begin
      rd_lo[b] <= mem[b][lo_a];
      rd_hi[b] <= mem[b][hi_a];
    end
  end

  assign lo   = rd_lo[s1_sel];
  assign hi   = rd_hi[s1_sel];
  assign diff = $signed({1'b0, hi}) - $signed({1'b0, lo});
  assign prod = diff * $signed({1'b0, s1_frac});
  assign sum  = $signed({1'b0, lo}) + (prod >>> FRAC_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0; s2_vld <= 1'b0; pix_valid_o <= 1'b0;
      s1_use <= 1'b0; s2_use <= 1'b0; s1_sel <= 1'b0;
      s1_frac <= '0; s1_pix <= '0; s2_pix <= '0; s2_val <= '0; pix_o <= '0;
    end else begin
      s1_vld  <= pix_valid_i;
      s1_use  <= lut_on;
      s1_sel  <= sel;
      s1_frac <= pix_i[FRAC_W-1:0];
      s1_pix  <= pix_i;
      s2_vld  <= s1_vld;
      s2_use  <= s1_use;
      s2_pix  <= s1_pix;
      s2_val  <= sum[DATA_W-1:0];
      pix_valid_o <= s2_vld;
      pix_o       <= s2_use ? s2_val : s2_pix;
    end
  end

  // R7: valid travels with the data
  assert_valid_pipe_R7: assert property (@(posedge clk) disable iff (rst)
    s2_vld |=> pix_valid_o);

  // R2: a pixel without table use leaves unchanged
  assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    (s2_vld && !s2_use) |=> (pix_o == $past(s2_pix)));
endmodule

// File: rtl/lut1d_dbuf.sv
module lut1d_dbuf
  import lut1d_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int IDX_W   = 4,
  parameter int PWR_LAT = 8,
  localparam int AW     = $clog2((2**IDX_W) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              frame_start,
  input  logic              pix_valid_i,
  input  logic [DATA_W-1:0] pix_r_i,
  input  logic [DATA_W-1:0] pix_g_i,
  input  logic [DATA_W-1:0] pix_b_i,
  output logic              pix_valid_o,
  output logic [DATA_W-1:0] pix_r_o,
  output logic [DATA_W-1:0] pix_g_o,
  output logic [DATA_W-1:0] pix_b_o
);
  logic              lut_on, sel_cur, host_sel, wr_en;
  logic [2:0]        wmask;
  logic [AW-1:0]     wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] ch_in  [3];
  logic [DATA_W-1:0] ch_out [3];
  logic [2:0]        ch_vld;
  logic              unused_vld;

  lut1d_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W), .PWR_LAT(PWR_LAT)) u_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .lut_on(lut_on), .sel_cur(sel_cur), .host_sel(host_sel), .wmask(wmask),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // channel c follows mask bit c: 0 blue, 1 green, 2 red
  assign ch_in[0] = pix_b_i;
  assign ch_in[1] = pix_g_i;
  assign ch_in[2] = pix_r_i;

  for (genvar c = 0; c < 3; c++) begin : g_ch
    lut1d_chan #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chan (
      .clk(clk), .rst(rst),
      .wr_en(wr_en && wmask[c]), .wr_bank(host_sel),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .lut_on(lut_on), .sel(sel_cur),
      .pix_valid_i(pix_valid_i), .pix_i(ch_in[c]),
      .pix_valid_o(ch_vld[c]), .pix_o(ch_out[c])
    );
  end

  assign pix_b_o     = ch_out[0];
  assign pix_g_o     = ch_out[1];
  assign pix_r_o     = ch_out[2];
  assign pix_valid_o = ch_vld[0];
  assign unused_vld  = ^ch_vld[2:1];
endmodule

// File: tb/sim_lut1d_dbuf.sv
`timescale 1ns/1ps
module sim_lut1d_dbuf;
  localparam int DW = 12, IW = 4, LAT = 8, FW = DW - IW, NE = (2**IW) + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, frame_start = 1'b0, pix_valid_i = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [DW-1:0] pix_r_i = '0, pix_g_i = '0, pix_b_i = '0;
  logic [DW-1:0] pix_r_o, pix_g_o, pix_b_o;
  logic pix_valid_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  lut1d_dbuf #(.DATA_W(DW), .IDX_W(IW), .PWR_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .pix_valid_i(pix_valid_i), .pix_r_i(pix_r_i), .pix_g_i(pix_g_i), .pix_b_i(pix_b_i),
    .pix_valid_o(pix_valid_o), .pix_r_o(pix_r_o), .pix_g_o(pix_g_o), .pix_b_o(pix_b_o)
  );

  // stimulus vectors {red, green, blue}
  localparam logic [35:0] PIX_TAB [8] = '{
    {12'h000, 12'h000, 12'h000},
    {12'hFFF, 12'hFFF, 12'hFFF},
    {12'h180, 12'h7FF, 12'hA5C},
    {12'h123, 12'h456, 12'h789},
    {12'hFFF, 12'h800, 12'h001},
    {12'h3C0, 12'hC3F, 12'h5A5},
    {12'hE10, 12'h0FF, 12'hF00},
    {12'h7F0, 12'h010, 12'hEEE}
  };

  // curve contents: bank 0 per channel (0 blue, 1 green, 2 red), bank 1 shared
  function automatic int ent(int bank, int ch, int k);
    if (bank == 1) return k * 100 + 50;
    if (ch == 2) return k * 240;
    if (ch == 1) return 4095 - k * 240;
    return k * k * 15;
  endfunction

  function automatic int model(int bank, int ch, int p);
    int i = p >> FW;
    int f = p & ((1 << FW) - 1);
    int lo = ent(bank, ch, i);
    int hi = ent(bank, ch, i + 1);
    return lo + (((hi - lo) * f) >>> FW);
  endfunction

  function automatic logic [31:0] cw(int mode, int sel, int host, int mask, int frc);
    return 32'(mode | (sel << 2) | (host << 3) | (mask << 4) | (frc << 8));
  endfunction

  task automatic chk(string req, bit ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(posedge clk); #1 d = reg_rdata;
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic send_px(logic [35:0] v, output logic [35:0] o, output logic ov);
    @(negedge clk); pix_valid_i = 1'b1; {pix_r_i, pix_g_i, pix_b_i} = v;
    @(negedge clk); pix_valid_i = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    o = {pix_r_o, pix_g_o, pix_b_o}; ov = pix_valid_o;
  endtask

  function automatic logic [35:0] expect_px(int bank, logic [35:0] v);
    return {12'(model(bank, 2, int'(v[35:24]))), 12'(model(bank, 1, int'(v[23:12]))),
            12'(model(bank, 0, int'(v[11:0])))};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [35:0] o, e;
    logic ov;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rreg(2'd0, rd); chk("R1 ctrl", rd == 32'h70, rd, 32'h70);
    rreg(2'd1, rd); chk("R1 index", rd == 0, rd, 0);
    // R2: mode 0 passes pixels through
    send_px(PIX_TAB[2], o, ov);
    chk("R2 mode0", o == PIX_TAB[2] && ov, o, PIX_TAB[2]);

    // R5: bank A loaded one channel at a time via the mask
    for (int ch = 2; ch >= 0; ch--) begin
      wreg(2'd0, cw(0, 0, 0, 1 << ch, 0));
      wreg(2'd1, 0);
      for (int k = 0; k < NE; k++) wreg(2'd2, 32'(ent(0, ch, k)));
    end
    // R3/R5: bank B loaded through mask 7
    wreg(2'd0, cw(0, 0, 1, 7, 0));
    wreg(2'd1, 0);
    for (int k = 0; k < NE; k++) wreg(2'd2, 32'(ent(1, 0, k)));
    rreg(2'd1, rd); chk("R6 auto-increment", rd == NE, rd, NE);
    wreg(2'd1, 3);
    rreg(2'd1, rd); chk("R6 index load", rd == 3, rd, 3);

    // R4: request without frame strobe does nothing
    wreg(2'd0, cw(2, 0, 1, 7, 0));
    send_px(PIX_TAB[3], o, ov);
    chk("R4 no strobe bypass", o == PIX_TAB[3], o, PIX_TAB[3]);
    rreg(2'd0, rd); chk("R4 mode_cur held", rd[17:16] == 0, rd[17:16], 0);
    frame();
    rreg(2'd0, rd); chk("R4 mode_cur applied", rd[17:16] == 2, rd[17:16], 2);

    // R7/R3: bank A curves, walked over the vector table
    foreach (PIX_TAB[n]) begin
      send_px(PIX_TAB[n], o, ov);
      e = expect_px(0, PIX_TAB[n]);
      chk("R7 bank A lookup", o == e && ov, o, e);
    end

    // R4: control write and frame strobe in the same cycle
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = cw(2, 1, 1, 7, 0);
    frame_start = 1'b1;
    @(negedge clk); reg_wr = 1'b0; frame_start = 1'b0;
    rreg(2'd0, rd); chk("R4 same-cycle keeps old select", rd[18] == 1'b0, rd[18], 0);
    send_px(PIX_TAB[5], o, ov); e = expect_px(0, PIX_TAB[5]);
    chk("R4 still bank A", o == e, o, e);
    frame();
    rreg(2'd0, rd); chk("R4 select applied", rd[18] == 1'b1, rd[18], 1);

    // R3/R5: bank B (mask 7 wrote all channels)
    foreach (PIX_TAB[n]) begin
      send_px(PIX_TAB[n], o, ov);
      e = expect_px(1, PIX_TAB[n]);
      chk("R3 bank B lookup", o == e && ov, o, e);
    end

    // R10: write to idle bank A in the same cycle as a bank B lookup
    wreg(2'd0, cw(2, 1, 0, 7, 0));
    wreg(2'd1, 5);
    fork
      wreg(2'd2, 32'hFFF);
      send_px({12'h500, 12'h500, 12'h500}, o, ov);
    join
    e = expect_px(1, {12'h500, 12'h500, 12'h500});
    chk("R10 active bank undisturbed", o == e, o, e);
    wreg(2'd0, cw(2, 0, 0, 7, 0)); frame();
    send_px({12'h500, 12'h500, 12'h500}, o, ov);
    chk("R3 host bank wrote A", o == {3{12'hFFF}}, o, {3{12'hFFF}});

    // R2: modes 1 and 3 are bypass
    wreg(2'd0, cw(1, 0, 0, 7, 0)); frame();
    send_px(PIX_TAB[6], o, ov);
    chk("R2 mode1", o == PIX_TAB[6], o, PIX_TAB[6]);
    wreg(2'd0, cw(3, 0, 0, 7, 0)); frame();
    send_px(PIX_TAB[7], o, ov);
    chk("R2 mode3", o == PIX_TAB[7], o, PIX_TAB[7]);

    // R8/R9: low power
    wreg(2'd0, cw(2, 0, 0, 7, 1)); frame();
    rreg(2'd0, rd); chk("R8 forced busy", rd[19] == 1'b1, rd[19], 1);
    send_px(PIX_TAB[4], o, ov);
    chk("R9 bypass in low power", o == PIX_TAB[4], o, PIX_TAB[4]);
    wreg(2'd1, 0);
    wreg(2'd2, 32'hABC);
    rreg(2'd1, rd); chk("R9 pointer unchanged", rd == 0, rd, 0);
    wreg(2'd0, cw(2, 0, 0, 7, 0));
    rreg(2'd0, rd); chk("R8 busy while waking", rd[19] == 1'b1, rd[19], 1);
    repeat (LAT + 2) @(posedge clk);
    rreg(2'd0, rd); chk("R8 ready after wake", rd[19] == 1'b0, rd[19], 0);
    send_px(PIX_TAB[0], o, ov); e = expect_px(0, PIX_TAB[0]);
    chk("R9 table not written", o == e, o, e);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule